// File: doc/BRIEF.md
# Parallel EPROM Program-and-Verify Sequencer

This block takes a parallel EPROM through one complete programming session. A single start pulse, with a byte count, begins the session. The sequencer first programs every address from zero up to the count minus one. It then goes back to address zero and reads every cell back in a separate pass. The byte meant for each address comes from a data source. The sequencer presents the address on `src_addr` and expects the matching byte on `src_data` in the same cycle.

The device side has an address bus, a bidirectional data bus, an active-low chip enable, and one shared pin that selects the data direction. The direction pin is 1 in the programming direction, where the programming voltage is applied and the controller drives the bus. It is 0 in the read direction, where the output is enabled and the device drives the bus. Address setup, data setup, the read data valid time, the program pulse width and the hold time are all counted in system clock cycles.

If a cell reads back wrong, the sequencer reprograms that single cell and reads it again. It allows a bounded number of reprograms. When the bound is used up, it stops and reports a failure together with the address and the retry count.

Top module: `eprom_prog_verify`

## Requirements
- R1: After reset, `busy`, `done` and `fail` are 0, `rom_ce_n` is 1, `rom_oe_vpp` is 1 (programming direction), and the controller does not drive the data bus.
- R2: When `byte_count` is nonzero, all addresses 0 to `byte_count`-1 each receive one program pulse, in ascending order, before the first verify read is issued.
- R3: In a program cycle, `rom_oe_vpp`=1 and the controller drives `src_data` for the current address. The address and data are held for max(T_AS,T_DS) cycles before `rom_ce_n` falls. `rom_ce_n` then stays low for exactly T_PW cycles, and the address and data are held for T_HOLD cycles after `rom_ce_n` rises. The device takes the byte at that rising edge.
- R4: In a verify cycle, `rom_oe_vpp`=0 and the address is set T_AS cycles before `rom_ce_n` falls. `rom_ce_n` stays low for exactly T_DV cycles, and the data bus is captured at the clock edge on which `rom_ce_n` returns high.
- R5: The controller drives the data bus only while `rom_oe_vpp`=1. Each change of `rom_oe_vpp` happens in a cycle with `rom_ce_n`=1 and the bus released.
- R6: A cell that reads back wrong is reprogrammed alone and then read again, up to MAX_RETRY (default 10) reprograms. A cell that needs 1+MAX_RETRY pulses still passes.
- R7: If a cell still reads back wrong after MAX_RETRY reprograms, the session ends with `done`=1 and `fail`=1. `fail_addr` holds that address and `retries` equals MAX_RETRY. No cell after it is verified or pulsed again.
- R8: `busy` is 1 from the cycle after an accepted start until completion. After a clean session, `done`=1, `fail`=0, every cell in range holds its source byte, and `retries` gives the reprogram count of the last address.
- R9: A start with `byte_count`=0 sets `done`=1 and `fail`=0 one cycle later, without any chip-enable pulse.
- R10: A start pulse while `busy` is 1 has no effect. The session continues with the count latched at the original start.
- R11: Addresses at or above `byte_count` are never pulsed and keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a session (sampled only when idle) |
| byte_count | input | ADDR_W+1 | Number of cells to program, 0 to 2^ADDR_W |
| src_addr | output | ADDR_W | Address whose source byte is wanted |
| src_data | input | DATA_W | Source byte for `src_addr`, same cycle |
| rom_addr | output | ADDR_W | Device address bus |
| rom_data | inout | DATA_W | Device data bus |
| rom_ce_n | output | 1 | Device chip enable, active low |
| rom_oe_vpp | output | 1 | Shared direction pin: 1 program voltage/input, 0 output enable |
| busy | output | 1 | Session in progress |
| done | output | 1 | Session finished (held until next start) |
| fail | output | 1 | Session ended on an unrecoverable cell |
| fail_addr | output | ADDR_W | Address of the unrecoverable cell |
| retries | output | $clog2(MAX_RETRY+1) | Reprograms used on the most recently verified address |

## Verification
The bench uses a device model with three behaviours. A cell programs only after its configured number of pulses. Programming can only clear bits. The model drives inverted data until T_DV cycles of read enable have passed. The stimulus covers several groups. Random images on erased parts with single-pulse cells separate the two-pass ordering and the pulse timing from the retry logic. Random weak cells, and a cell needing exactly 1+MAX_RETRY pulses, test the retry count and its bound. A cell needing one pulse more than that, and a cell with a cleared bit the image needs set, both test abort at the right address. A zero count, a full-range count and a start pulse during a busy session test the count handling and show that out-of-range cells are untouched.

// File: rtl/epv_pkg.sv
package epv_pkg;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_PSET   = 3'd1,
        S_PPULSE = 3'd2,
        S_PHOLD  = 3'd3,
        S_TURN   = 3'd4,
        S_VSET   = 3'd5,
        S_VREAD  = 3'd6,
        S_VCHECK = 3'd7
    } epv_state_e;

    function automatic int epv_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/epv_delay.sv
module epv_delay #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

    // a loaded dwell is visible on the next cycle (R3, R4 timing base)
    p_load_dwell_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/epv_bus_pad.sv
module epv_bus_pad #(
    parameter int W = 8
) (
    input  logic         drive,
    input  logic [W-1:0] dout,
    output logic [W-1:0] din,
    inout  wire  [W-1:0] pad
);

    assign pad = drive ? dout : {W{1'bz}};
    assign din = pad;

endmodule

// File: rtl/eprom_prog_verify.sv
module eprom_prog_verify
    import epv_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int T_AS      = 2,
    parameter int T_DS      = 2,
    parameter int T_DV      = 3,
    parameter int T_PW      = 4,
    parameter int T_HOLD    = 1,
    parameter int MAX_RETRY = 10,
    localparam int CNT_W    = ADDR_W + 1,
    localparam int RET_W    = $clog2(MAX_RETRY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  byte_count,
    output logic [ADDR_W-1:0] src_addr,
    input  logic [DATA_W-1:0] src_data,
    output logic [ADDR_W-1:0] rom_addr,
    inout  wire  [DATA_W-1:0] rom_data,
    output logic              rom_ce_n,
    output logic              rom_oe_vpp,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [RET_W-1:0]  retries
);

    localparam int T_SETUP = epv_max(T_AS, T_DS);
    localparam int T_MAX   = epv_max(epv_max(T_SETUP, T_DV), epv_max(T_PW, T_HOLD));
    localparam int TIM_W   = $clog2(T_MAX) + 1;

    localparam logic [TIM_W-1:0] LD_SETUP = TIM_W'(T_SETUP - 1);
    localparam logic [TIM_W-1:0] LD_AS    = TIM_W'(T_AS - 1);
    localparam logic [TIM_W-1:0] LD_DV    = TIM_W'(T_DV - 1);
    localparam logic [TIM_W-1:0] LD_PW    = TIM_W'(T_PW - 1);
    localparam logic [TIM_W-1:0] LD_HOLD  = TIM_W'(T_HOLD - 1);
    localparam logic [RET_W-1:0] RET_LIM  = RET_W'(MAX_RETRY);

    typedef struct packed {
        epv_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] last;
        logic [RET_W-1:0]  retry;
        logic              redo;
        logic              ce_n;
        logic              oe_vpp;
        logic              drv;
        logic              done;
        logic              fail;
        logic [ADDR_W-1:0] fail_addr;
        logic [DATA_W-1:0] rd;
    } ctl_t;

    ctl_t              r_d, r_q;
    logic              t_load;
    logic [TIM_W-1:0]  t_val;
    logic              t_exp;
    logic [DATA_W-1:0] bus_in;

    epv_delay #(.W(TIM_W)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    epv_bus_pad #(.W(DATA_W)) u_pad (
        .drive (r_q.drv),
        .dout  (src_data),
        .din   (bus_in),
        .pad   (rom_data)
    );

    always_comb begin
        r_d    = r_q;
        t_load = 1'b0;
        t_val  = '0;
        unique case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.done      = 1'b0;
                    r_d.fail      = 1'b0;
                    r_d.fail_addr = '0;
                    r_d.retry     = '0;
                    r_d.addr      = '0;
                    r_d.redo      = 1'b0;
                    if (byte_count == '0) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.last   = byte_count[ADDR_W-1:0] - 1'b1;
                        r_d.st     = S_PSET;
                        r_d.oe_vpp = 1'b1;
                        r_d.drv    = 1'b1;
                        t_load     = 1'b1;
                        t_val      = LD_SETUP;
                    end
                end
            end
            S_PSET: begin
                if (t_exp) begin
                    r_d.st   = S_PPULSE;
                    r_d.ce_n = 1'b0;
                    t_load   = 1'b1;
                    t_val    = LD_PW;
                end
            end
            S_PPULSE: begin
                if (t_exp) begin
                    r_d.st   = S_PHOLD;
                    r_d.ce_n = 1'b1;
                    t_load   = 1'b1;
                    t_val    = LD_HOLD;
                end
            end
            S_PHOLD: begin
                if (t_exp) begin
                    if (r_q.redo || (r_q.addr == r_q.last)) begin
                        r_d.st     = S_TURN;
                        r_d.drv    = 1'b0;
                        r_d.oe_vpp = 1'b0;
                        if (!r_q.redo) begin
                            r_d.addr = '0;
                        end
                    end else begin
                        r_d.st   = S_PSET;
                        r_d.addr = r_q.addr + 1'b1;
                        t_load   = 1'b1;
                        t_val    = LD_SETUP;
                    end
                end
            end
            S_TURN: begin
                if (r_q.oe_vpp) begin
                    r_d.st  = S_PSET;
                    r_d.drv = 1'b1;
                    t_load  = 1'b1;
                    t_val   = LD_SETUP;
                end else begin
                    r_d.st = S_VSET;
                    t_load = 1'b1;
                    t_val  = LD_AS;
                end
            end
            S_VSET: begin
                if (t_exp) begin
                    r_d.st   = S_VREAD;
                    r_d.ce_n = 1'b0;
                    t_load   = 1'b1;
                    t_val    = LD_DV;
                end
            end
            S_VREAD: begin
                if (t_exp) begin
                    r_d.st   = S_VCHECK;
                    r_d.ce_n = 1'b1;
                    r_d.rd   = bus_in;
                end
            end
            S_VCHECK: begin
                if (r_q.rd == src_data) begin
                    r_d.redo = 1'b0;
                    if (r_q.addr == r_q.last) begin
                        r_d.st     = S_IDLE;
                        r_d.done   = 1'b1;
                        r_d.oe_vpp = 1'b1;
                    end else begin
                        r_d.st    = S_VSET;
                        r_d.addr  = r_q.addr + 1'b1;
                        r_d.retry = '0;
                        t_load    = 1'b1;
                        t_val     = LD_AS;
                    end
                end else if (r_q.retry == RET_LIM) begin
                    r_d.st        = S_IDLE;
                    r_d.done      = 1'b1;
                    r_d.fail      = 1'b1;
                    r_d.fail_addr = r_q.addr;
                    r_d.oe_vpp    = 1'b1;
                end else begin
                    r_d.st     = S_TURN;
                    r_d.retry  = r_q.retry + 1'b1;
                    r_d.redo   = 1'b1;
                    r_d.oe_vpp = 1'b1;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.ce_n   <= 1'b1;
            r_q.oe_vpp <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign src_addr   = r_q.addr;
    assign rom_addr   = r_q.addr;
    assign rom_ce_n   = r_q.ce_n;
    assign rom_oe_vpp = r_q.oe_vpp;
    assign busy       = (r_q.st != S_IDLE);
    assign done       = r_q.done;
    assign fail       = r_q.fail;
    assign fail_addr  = r_q.fail_addr;
    assign retries    = r_q.retry;

    // bus driven only in the programming direction
    p_drive_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.drv |-> r_q.oe_vpp);

    // direction flips only in a quiet cycle
    p_turn_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.oe_vpp) |-> (r_q.ce_n && !r_q.drv));

    // the controller starts driving only after a cycle already in program direction
    p_drive_after_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.drv) |-> $past(r_q.oe_vpp));

    // address does not move while chip enable is low or at its rising edge
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.ce_n |=> $stable(r_q.addr));

    // retry count never exceeds its bound
    p_retry_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.retry <= RET_LIM);

    // failure is only reported with completion
    p_fail_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.fail |-> (r_q.done && !busy));

    // completion and activity are exclusive
    p_busy_nodone_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !r_q.done);

endmodule

// File: tb/eprom_prog_verify_bench.sv
`timescale 1ns/1ps
module eprom_prog_verify_bench;

    localparam int AW       = 6;
    localparam int DW       = 8;
    localparam int CW       = AW + 1;
    localparam int DEPTH    = 1 << AW;
    localparam int TAS      = 2;
    localparam int TDS      = 3;
    localparam int TDV      = 3;
    localparam int TPW      = 4;
    localparam int THOLD    = 2;
    localparam int MAXR     = 10;
    localparam int WD_LIMIT = 190000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] byte_count = '0;
    logic [AW-1:0] src_addr, rom_addr, fail_addr;
    logic [DW-1:0] src_data;
    wire  [DW-1:0] rom_data;
    logic          rom_ce_n, rom_oe_vpp, busy, done, fail;
    logic [3:0]    retries;

    always #2.5 clk = ~clk;

    eprom_prog_verify #(
        .ADDR_W(AW), .DATA_W(DW), .T_AS(TAS), .T_DS(TDS), .T_DV(TDV),
        .T_PW(TPW), .T_HOLD(THOLD), .MAX_RETRY(MAXR)
    ) u_eprom_prog_verify (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
        .src_addr(src_addr), .src_data(src_data), .rom_addr(rom_addr),
        .rom_data(rom_data), .rom_ce_n(rom_ce_n), .rom_oe_vpp(rom_oe_vpp),
        .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
        .retries(retries)
    );

    // stimulus-side arrays (written only by the main initial block)
    logic [DW-1:0] img  [DEPTH];
    logic [DW-1:0] mem0 [DEPTH];
    int            need [DEPTH];
    logic          load = 1'b0;

    assign src_data = img[src_addr];

    // device model
    logic [DW-1:0] mem [DEPTH];
    int            pc  [DEPTH];
    logic          ce_prev = 1'b1;
    int            lw = 0;
    int            rdcnt = 0;
    int            prog_pulses = 0;
    int            read_pulses = 0;
    int            width_err = 0;
    int            prog_at_read = -1;
    int            cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (load) begin
            for (int a = 0; a < DEPTH; a++) begin
                mem[a] <= mem0[a];
                pc[a] = 0;
            end
            prog_pulses = 0;
            read_pulses = 0;
            width_err = 0;
            prog_at_read = -1;
        end else if (rom_ce_n && !ce_prev) begin
            if (rom_oe_vpp) begin
                prog_pulses++;
                if (lw != TPW) width_err++;
                if (pc[rom_addr] + 1 >= need[rom_addr])
                    mem[rom_addr] <= mem[rom_addr] & rom_data;
                pc[rom_addr] = pc[rom_addr] + 1;
            end else begin
                if (read_pulses == 0) prog_at_read = prog_pulses;
                read_pulses++;
                if (lw != TDV) width_err++;
            end
        end
        ce_prev <= rom_ce_n;
        lw      <= rom_ce_n ? 0 : lw + 1;
        rdcnt   <= (!rom_ce_n && !rom_oe_vpp) ? rdcnt + 1 : 0;
    end

    logic          dev_drv;
    logic [DW-1:0] dev_val;
    assign dev_drv  = !rom_ce_n && !rom_oe_vpp;
    assign dev_val  = (rdcnt + 1 >= TDV) ? mem[rom_addr] : ~mem[rom_addr];
    assign rom_data = dev_drv ? dev_val : {DW{1'bz}};

    int checks = 0;
    int errors = 0;

    task automatic chk_eq(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
        $finish;
    endtask

    task automatic fill_random();
        for (int a = 0; a < DEPTH; a++) begin
            img[a]  = DW'($urandom);
            mem0[a] = '1;
            need[a] = 1;
        end
    endtask

    task automatic run_case(input int cnt, input string tag, input bit poke_busy);
        int ef, ea, er, epulses;
        int ra [DEPTH];
        logic [DW-1:0] expm;
        ef = 0; ea = 0; er = 0; epulses = cnt;
        for (int a = 0; a < DEPTH; a++) ra[a] = 0;
        for (int a = 0; a < cnt; a++) begin
            bit okc;
            okc = ((mem0[a] & img[a]) == img[a]);
            if (!okc || need[a] - 1 > MAXR) begin
                ef = 1; ea = a; er = MAXR; ra[a] = MAXR; epulses += MAXR;
                break;
            end
            ra[a] = need[a] - 1; er = need[a] - 1; epulses += need[a] - 1;
        end

        @(negedge clk); load = 1'b1;
        @(negedge clk); load = 1'b0;
        @(negedge clk); start = 1'b1; byte_count = CW'(cnt);
        @(negedge clk); start = 1'b0;
        if (cnt > 0) chk_eq("R8", {tag, " busy after start"}, longint'(busy), 1);
        if (poke_busy) begin
            repeat (25) @(negedge clk);
            start = 1'b1; byte_count = CW'(DEPTH);
            @(negedge clk); start = 1'b0;
        end
        while (!done) begin
            @(negedge clk);
            if (cyc >= WD_LIMIT) begin
                chk_eq("R8", {tag, " watchdog expired"}, 0, 1);
                summary();
            end
        end
        chk_eq("R8", {tag, " busy at done"}, longint'(busy), 0);
        chk_eq(ef ? "R7" : "R8", {tag, " fail flag"}, longint'(fail), ef);
        if (ef) chk_eq("R7", {tag, " fail_addr"}, longint'(fail_addr), ea);
        chk_eq(ef ? "R7" : "R6", {tag, " retries"}, longint'(retries), er);
        chk_eq(poke_busy ? "R10" : "R6", {tag, " program pulses"}, prog_pulses, epulses);
        if (cnt > 0) chk_eq("R2", {tag, " pulses before first read"}, prog_at_read, cnt);
        else         chk_eq("R9", {tag, " no chip enable activity"}, prog_pulses + read_pulses, 0);
        chk_eq("R3", {tag, " pulse width errors (R4 reads too)"}, width_err, 0);
        for (int a = 0; a < DEPTH; a++) begin
            if (a < cnt && (1 + ra[a]) >= need[a]) expm = mem0[a] & img[a];
            else                                   expm = mem0[a];
            chk_eq(a < cnt ? "R8" : "R11", {tag, $sformatf(" cell %0d", a)}, longint'(mem[a]), longint'(expm));
        end
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        fill_random();
        repeat (4) @(negedge clk);
        chk_eq("R1", "reset busy", longint'(busy), 0);
        chk_eq("R1", "reset done", longint'(done), 0);
        chk_eq("R1", "reset fail", longint'(fail), 0);
        chk_eq("R1", "reset ce_n", longint'(rom_ce_n), 1);
        chk_eq("R1", "reset oe_vpp", longint'(rom_oe_vpp), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk_eq("R1", "idle ce_n after release", longint'(rom_ce_n), 1);

        // R9: empty session
        fill_random();
        run_case(0, "zero count", 1'b0);

        // R2/R3/R4/R8: random images on erased parts
        for (int k = 0; k < 5; k++) begin
            fill_random();
            run_case(int'($urandom_range(1, DEPTH - 1)), $sformatf("random %0d", k), 1'b0);
        end

        // R6: random weak cells, last cell weak
        for (int k = 0; k < 3; k++) begin
            int c;
            fill_random();
            c = int'($urandom_range(8, 40));
            for (int a = 0; a < DEPTH; a++)
                if ($urandom_range(0, 3) == 0) need[a] = int'($urandom_range(2, 4));
            need[c - 1] = 3;
            run_case(c, $sformatf("weak %0d", k), 1'b0);
        end

        // R6: cell at the retry bound passes, and last cell at the bound
        fill_random();
        need[5] = MAXR + 1;
        need[9] = MAXR + 1;
        run_case(10, "bound pass", 1'b0);

        // R7: one pulse beyond the bound
        fill_random();
        need[7] = MAXR + 2;
        need[11] = MAXR + 2;
        run_case(16, "bound exceeded", 1'b0);

        // R7: cell with a cleared bit the image wants set
        fill_random();
        img[3]  = 8'hF0;
        mem0[3] = 8'h7F;
        run_case(12, "unerased cell", 1'b0);

        // R8/R11: full range
        fill_random();
        run_case(DEPTH, "full range", 1'b0);

        // R10: start while busy is ignored
        fill_random();
        run_case(20, "start while busy", 1'b1);

        summary();
    end

endmodule